// File: doc/BRIEF.md
# Array Execution Control Sequencer

This block drives a reconfigurable processing array cycle by cycle, so the host processor does not have to issue a bus transaction for every array cycle. The host hands over one packed 64-bit control record through a valid/ready port. The record carries five things:

- how many array cycles to run;
- a 4-bit chip select;
- a read/write mode bit;
- a starting frame-buffer address;
- a starting configuration-cache address.

After accepting a record, the sequencer spends one cycle loading it. It then produces one frame-buffer strobe and one configuration-cache strobe per cycle. Both addresses advance by one on every strobe cycle. When the count is used up, the sequencer raises a one-cycle done pulse and becomes ready again.

The record port applies back-pressure in a simple way. `rec_ready` is high only while the sequencer is idle. A record presented while `rec_ready` is low is not taken and is not queued. The host must hold `rec_valid` until it sees `rec_ready` high on the same cycle. The `busy` output stays high from the cycle after acceptance until the sequencer has returned to idle.

Top module: `array_exec_seq`

## Requirements
- R1: After reset, `rec_ready` is 1, `busy` is 0, `fb_en`, `cc_en` and `done` are 0, and both address outputs are 0.
- R2: The record fields sit at fixed bit positions. The cycle count N is bits [15:0]. The chip select is bits [19:16]. The write mode is bit 20 (1 = write). The frame-buffer start is bits [35:24]. The cache start is bits [47:40]. All other bits are ignored.
- R3: A record is taken on a clock edge where `rec_valid` and `rec_ready` are both 1. The cycle after that edge is a load cycle, in which `busy` is 1, `rec_ready` is 0 and no strobe is issued.
- R4: For N > 0, `fb_en` and `cc_en` are both 1 for exactly N consecutive cycles, starting the cycle after the load cycle. During those cycles, `arr_cs` and `fb_we` equal the record's chip select and mode bit and do not change.
- R5: On the k-th strobe cycle (k from 0), `fb_addr` equals the frame-buffer start plus k, modulo 4096. On the same cycle, `cc_addr` equals the cache start plus k, modulo 256.
- R6: `done` is 1 for exactly one cycle, the cycle after the last strobe. On the following cycle, `rec_ready` is 1 and `busy` is 0.
- R7: A record with N = 0 issues no strobe. `done` rises on the cycle right after the load cycle.
- R8: While `busy` is 1, `rec_ready` is 0 and a presented record is dropped. It changes neither the running sequence nor anything after it: no further strobes follow the done pulse.
- R9: Outside strobe cycles, `fb_en`, `cc_en`, `fb_we` and `arr_cs` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_valid | input | 1 | Host presents a control record |
| rec_ready | output | 1 | Sequencer can take a record (idle) |
| rec_data | input | 64 | Packed control record |
| busy | output | 1 | A record is being loaded, run or finished |
| arr_cs | output | 4 | Array chip select during strobe cycles |
| fb_en | output | 1 | Frame-buffer access strobe |
| fb_we | output | 1 | Frame-buffer write mode during strobe cycles |
| fb_addr | output | 12 | Frame-buffer address |
| cc_en | output | 1 | Configuration-cache access strobe |
| cc_addr | output | 8 | Configuration-cache address |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The assertions check, on every cycle, these cycle-to-cycle properties:
- each address steps by one between consecutive strobe cycles;
- mode and chip select do not change during a run;
- an accepted record is followed by a strobe-free load cycle;
- the strobe run ends with a done pulse, and the sequencer is ready right after it.

Only the bench scenarios can show the exact properties of a run:
- the run length equals the decoded count;
- the first addresses equal the decoded starts, including wrap-around at the top of each address space;
- bits outside the fields are ignored;
- a record offered while busy leaves no trace.

// File: rtl/aes_pkg.sv
package aes_pkg;
  localparam int REC_W  = 64;
  localparam int CNT_W  = 16;
  localparam int CNT_LSB = 0;
  localparam int CS_W   = 4;
  localparam int CS_LSB = 16;
  localparam int RW_BIT = 20;
  localparam int FB_AW  = 12;
  localparam int FB_LSB = 24;
  localparam int CC_AW  = 8;
  localparam int CC_LSB = 40;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic [CNT_W-1:0] cycles;
    logic [CS_W-1:0]  cs;
    logic             wr;
    logic [FB_AW-1:0] fb_base;
    logic [CC_AW-1:0] cc_base;
  } ctl_rec_t;
endpackage

// File: rtl/aes_decode.sv
module aes_decode
  import aes_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [REC_W-1:0] rec_data,
  output ctl_rec_t         rec_q
);
  logic unused_bits;
  assign unused_bits = ^{rec_data[REC_W-1:CC_LSB+CC_AW],
                         rec_data[CC_LSB-1:FB_LSB+FB_AW],
                         rec_data[FB_LSB-1:RW_BIT+1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q <= '0;
    end else if (capture) begin
      rec_q.cycles  <= rec_data[CNT_LSB +: CNT_W];
      rec_q.cs      <= rec_data[CS_LSB +: CS_W];
      rec_q.wr      <= rec_data[RW_BIT];
      rec_q.fb_base <= rec_data[FB_LSB +: FB_AW];
      rec_q.cc_base <= rec_data[CC_LSB +: CC_AW];
    end
  end
endmodule

// File: rtl/aes_fsm.sv
module aes_fsm
  import aes_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cycles,
  output logic             load,
  output logic             run,
  output logic             fin,
  output logic             busy
);
  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_LOAD;
      ST_LOAD: begin
        cnt_d   = cycles;
        state_d = (cycles == '0) ? ST_DONE : ST_RUN;
      end
      ST_RUN: begin
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign load = (state_q == ST_LOAD);
  assign run  = (state_q == ST_RUN);
  assign fin  = (state_q == ST_DONE);
  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/aes_addr_gen.sv
module aes_addr_gen #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= base;
    else if (step) addr <= addr + 1'b1;
  end
endmodule

// File: rtl/array_exec_seq.sv
module array_exec_seq
  import aes_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rec_valid,
  output logic             rec_ready,
  input  logic [REC_W-1:0] rec_data,
  output logic             busy,
  output logic [CS_W-1:0]  arr_cs,
  output logic             fb_en,
  output logic             fb_we,
  output logic [FB_AW-1:0] fb_addr,
  output logic             cc_en,
  output logic [CC_AW-1:0] cc_addr,
  output logic             done
);
  ctl_rec_t rec_q;
  logic     accept, load, run, fin, busy_i;

  assign rec_ready = ~busy_i;
  assign accept    = rec_valid & rec_ready;

  aes_decode u_dec (
    .clk(clk), .rst_n(rst_n), .capture(accept),
    .rec_data(rec_data), .rec_q(rec_q)
  );

  aes_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(accept), .cycles(rec_q.cycles),
    .load(load), .run(run), .fin(fin), .busy(busy_i)
  );

  aes_addr_gen #(.AW(FB_AW)) u_fb_ag (
    .clk(clk), .rst_n(rst_n), .load(load), .step(run),
    .base(rec_q.fb_base), .addr(fb_addr)
  );

  aes_addr_gen #(.AW(CC_AW)) u_cc_ag (
    .clk(clk), .rst_n(rst_n), .load(load), .step(run),
    .base(rec_q.cc_base), .addr(cc_addr)
  );

  assign busy   = busy_i;
  assign fb_en  = run;
  assign cc_en  = run;
  assign fb_we  = run & rec_q.wr;
  assign arr_cs = run ? rec_q.cs : '0;
  assign done   = fin;
endmodule

// File: rtl/aes_checker.sv
module aes_checker
  import aes_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             rec_valid,
  input logic             rec_ready,
  input logic             busy,
  input logic [CS_W-1:0]  arr_cs,
  input logic             fb_en,
  input logic             fb_we,
  input logic [FB_AW-1:0] fb_addr,
  input logic             cc_en,
  input logic [CC_AW-1:0] cc_addr,
  input logic             done
);
  a_r3_load_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_ready) |=> (busy && !fb_en && !cc_en));

  a_r5_fb_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_en && $past(fb_en)) |-> (fb_addr == $past(fb_addr) + 1'b1));

  a_r5_cc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_en && $past(cc_en)) |-> (cc_addr == $past(cc_addr) + 1'b1));

  a_r4_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_en && $past(fb_en)) |-> ($stable(fb_we) && $stable(arr_cs)));

  a_r6_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fb_en) |-> done);

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && rec_ready));

  a_r8_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rec_ready |-> (!fb_en && !cc_en && !done));

  a_r9_quiet_off_run: assert property (@(posedge clk) disable iff (!rst_n)
    !fb_en |-> (!fb_we && arr_cs == '0 && !cc_en));
endmodule

bind array_exec_seq aes_checker u_chk (.*);

// File: tb/array_exec_seq_test.sv
module array_exec_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rec_valid = 1'b0;
  logic        rec_ready;
  logic [63:0] rec_data = '0;
  logic        busy;
  logic [3:0]  arr_cs;
  logic        fb_en, fb_we, cc_en, done;
  logic [11:0] fb_addr;
  logic [7:0]  cc_addr;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  array_exec_seq uut (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_data(rec_data), .busy(busy), .arr_cs(arr_cs), .fb_en(fb_en),
    .fb_we(fb_we), .fb_addr(fb_addr), .cc_en(cc_en), .cc_addr(cc_addr),
    .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] mk(input int cyc, input int cs, input int rw,
                                     input int fb, input int cc, input bit junk);
    logic [63:0] r;
    r = junk ? 64'hFFFF_00F0_00E0_0000 : 64'h0;
    r[15:0]  = cyc[15:0];
    r[19:16] = cs[3:0];
    r[20]    = rw[0];
    r[35:24] = fb[11:0];
    r[47:40] = cc[7:0];
    return r;
  endfunction

  // inj: -1 none, 0 during load cycle, k+1 during strobe cycle k
  task automatic run_rec(input int cyc, input int cs, input int rw,
                         input int fb, input int cc, input bit junk, input int inj);
    logic [11:0] efb;
    logic [7:0]  ecc;
    @(negedge clk);
    chk(rec_ready == 1'b1, "R3 ready before offer", rec_ready, 1);
    rec_valid = 1'b1;
    rec_data  = mk(cyc, cs, rw, fb, cc, junk);
    @(negedge clk);
    rec_valid = 1'b0;
    chk(busy && !rec_ready && !fb_en && !cc_en, "R3 load cycle",
        {busy, rec_ready, fb_en, cc_en}, 4'b1000);
    chk(arr_cs == 0 && fb_we == 0, "R9 quiet in load", {arr_cs, fb_we}, 0);
    if (inj == 0) begin
      rec_valid = 1'b1;
      rec_data  = mk(3, 15, 1, 100, 50, 1'b0);
    end
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      rec_valid = 1'b0;
      efb = 12'(fb + k);
      ecc = 8'(cc + k);
      chk(fb_en && cc_en, "R4 strobe", {fb_en, cc_en}, 2'b11);
      chk(arr_cs == 4'(cs) && fb_we == rw[0], "R4 cs/mode",
          {arr_cs, fb_we}, {4'(cs), rw[0]});
      chk(fb_addr == efb, "R5 fb addr", fb_addr, efb);
      chk(cc_addr == ecc, "R5 cc addr", cc_addr, ecc);
      chk(!rec_ready, "R8 not ready in run", rec_ready, 0);
      if (inj == k + 1) begin
        rec_valid = 1'b1;
        rec_data  = mk(0, 7, 0, 5, 5, 1'b0);
      end
    end
    @(negedge clk);
    rec_valid = 1'b0;
    if (cyc == 0)
      chk(done && !fb_en && !cc_en, "R7 zero count done", {done, fb_en, cc_en}, 3'b100);
    else
      chk(done && !fb_en && !cc_en, "R6 done after last", {done, fb_en, cc_en}, 3'b100);
    chk(arr_cs == 0 && fb_we == 0, "R9 quiet in done", {arr_cs, fb_we}, 0);
    @(negedge clk);
    chk(!done && rec_ready && !busy, "R6 back to idle", {done, rec_ready, busy}, 3'b010);
    if (inj >= 0) begin
      @(negedge clk);
      chk(!fb_en && !done && !busy, "R8 dropped record", {fb_en, done, busy}, 0);
      @(negedge clk);
      chk(!fb_en && !done && !busy, "R8 dropped record", {fb_en, done, busy}, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + 2);
    @(negedge clk);
    chk(rec_ready && !busy && !fb_en && !cc_en && !done, "R1 reset outputs",
        {rec_ready, busy, fb_en, cc_en, done}, 5'b10000);
    chk(fb_addr == 0 && cc_addr == 0, "R1 reset addrs", {fb_addr, cc_addr}, 0);
    rst_n = 1'b1;
    // R1 again after release, before any record
    @(negedge clk);
    chk(rec_ready && !busy, "R1 idle after release", {rec_ready, busy}, 2'b10);

    // R4 R5 R6 R7 sweep over counts, including address wrap
    for (int n = 0; n <= 9; n++)
      run_rec(n, n % 16, n % 2, 12'hFFC + n, 8'hFC + 3 * n, 1'b0, -1);
    // R4 R9: every chip select, both modes
    for (int c = 0; c < 16; c++)
      run_rec(2, c, (c >> 1) & 1, c * 37, c * 11, 1'b0, -1);
    // R2: bits outside the fields set
    for (int n = 0; n < 4; n++)
      run_rec(n, 9, 1, 12'h800 + n, 8'h80, 1'b1, -1);
    // R8: offers while busy in load, mid-run and on the last strobe
    run_rec(5, 3, 1, 200, 20, 1'b0, 0);
    run_rec(5, 3, 0, 300, 30, 1'b0, 3);
    run_rec(5, 6, 1, 12'hFFF, 8'hFF, 1'b0, 5);
    run_rec(0, 2, 1, 7, 7, 1'b0, 0);
    // a longer run
    run_rec(300, 10, 1, 12'hF00, 8'h10, 1'b1, 150);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule